// File: doc/BRIEF.md
# SPI Command Register Target

This block is the host-facing register port of a CAN controller, reached over SPI. Every chip-select frame opens with a one-byte opcode. The opcode selects one of three actions that follow it: a register write that consumes one data byte, a register read that returns one data byte, or a FIFO stream that runs until chip select rises. A one-byte reset opcode puts the controller back into its initial mode. The CAN protocol engine is not part of this block. The block exposes the configuration it holds on plain outputs. It takes the engine's events and counters on plain inputs, and it exchanges FIFO bytes with the engine through a one-cycle strobe on each side.

The SPI pins are sampled with the system clock through synchronizers, so SCK must run well below the system clock. Inside the block, the frame decoder reaches the register file through a small port that carries a write strobe, a read strobe and a reset strobe. Because the flag registers clear when they are read, a read has side effects, and the decoder issues at most one read per frame.

Top module: `spi_cmd_target`

## Requirements
- R1: The SPI link uses mode 0 (data sampled on the SCK rising edge, changed on the falling edge), most significant bit first. The first byte of each frame is the opcode, and MISO returns 0x00 while the opcode byte is shifted.
- R2: Opcode 0x14, 0x16, 0x18, 0x1A or 0x1C followed by one data byte writes that byte to CTRL0, CTRL1, BTR0, BTR1 or the interrupt-enable register respectively. Any bytes after the data byte in the same frame are ignored.
- R3: Opcodes 0xD2, 0xD4, 0xD6 and 0xD8 return CTRL0, CTRL1, BTR0 and BTR1 in the second byte slot of the frame. Opcodes 0xDA, 0xEA and 0xEC return the message-status, receive-error-count and transmit-error-count inputs in that slot. Every later slot in the frame returns 0x00.
- R4: After the synchronous reset, CTRL0 reads 0x80, which is mode 4 (init). CTRL1, BTR0, BTR1, interrupt enable, interrupt flags and error flags read 0x00, and the status register reads 0x82.
- R5: The one-byte opcode 0x56 returns CTRL0 to 0x80 and clears CTRL1, BTR0, BTR1, interrupt enable and interrupt flags. It also sets status to 0x82. The error-flag register keeps its value.
- R6: cfg_mode always equals CTRL0 bits 7:5, where 0 is normal, 1 loopback, 2 monitor, 3 sleep and 4 init. CTRL1, BTR0, BTR1 and interrupt enable appear on their cfg outputs.
- R7: The interrupt-flag register (read opcode 0xDE) ORs in the int_set bits on every cycle. A read returns the accumulated value and clears it, except for bits that are set in the same cycle as the read.
- R8: The error-flag register (read opcode 0xDC) ORs in the err_set bits on every cycle. A read returns the accumulated value and clears it.
- R9: The status register (read opcode 0xE2) loads stat_value when stat_load is high. Reading it does not change it.
- R10: After opcode 0x12, each complete byte received is presented on txf_data with a one-cycle txf_valid pulse, and MISO returns 0x00.
- R11: After opcode 0x48, each byte slot shifts out the current rxf_data. A one-cycle rxf_pop pulse follows each completed slot.
- R12: A chip-select deassertion abandons any partial opcode or data byte without applying it. The next frame decodes a fresh opcode.
- R13: An opcode not listed above returns 0x00 in every later slot, and the data bytes that follow it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| int_set | input | 8 | Interrupt-flag set bits from the engine |
| err_set | input | 8 | Error-flag set bits from the engine |
| stat_load | input | 1 | Load strobe for the status register |
| stat_value | input | 8 | Value loaded into status |
| msg_stat_in | input | 8 | Message status value returned by opcode 0xDA |
| rec_in | input | 8 | Receive error count |
| tec_in | input | 8 | Transmit error count |
| rxf_data | input | 8 | Head byte of the receive FIFO |
| rxf_pop | output | 1 | Receive FIFO head consumed |
| txf_valid | output | 1 | Transmit FIFO byte strobe |
| txf_data | output | 8 | Transmit FIFO byte |
| cfg_mode | output | 3 | Operating mode, CTRL0 bits 7:5 |
| cfg_ctrl1 | output | 8 | CTRL1 contents |
| cfg_btr0 | output | 8 | BTR0 contents |
| cfg_btr1 | output | 8 | BTR1 contents |
| cfg_inten | output | 8 | Interrupt-enable contents |

## Verification
A read of a clear-on-read register is issued twice in a row, so a design that clears too early returns zero the first time, and a design that never clears returns the old flags the second time. The reset opcode is sent with error flags pending, and the test catches a design that wipes those flags along with the configuration. Frames are cut off in the middle of an opcode and in the middle of a write data byte, which exposes a decoder that commits half a byte or carries a stale bit count into the next frame. Unknown opcodes followed by data, and extra bytes after a write, catch a decoder that writes a register it was never told to write. The FIFO streams check byte order and the count of pops, which catches a design that loses or repeats the head byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int BYTE_W    = 8;
    localparam int BITCNT_W  = $clog2(BYTE_W);
    localparam int MODE_W    = 3;
    localparam int MODE_LSB  = BYTE_W - MODE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_W_CTRL0 = 8'h14;
    localparam byte_t OP_W_CTRL1 = 8'h16;
    localparam byte_t OP_W_BTR0  = 8'h18;
    localparam byte_t OP_W_BTR1  = 8'h1A;
    localparam byte_t OP_W_INTEN = 8'h1C;
    localparam byte_t OP_TX_FIFO = 8'h12;
    localparam byte_t OP_R_CTRL0 = 8'hD2;
    localparam byte_t OP_R_CTRL1 = 8'hD4;
    localparam byte_t OP_R_BTR0  = 8'hD6;
    localparam byte_t OP_R_BTR1  = 8'hD8;
    localparam byte_t OP_R_MSTAT = 8'hDA;
    localparam byte_t OP_R_ERRF  = 8'hDC;
    localparam byte_t OP_R_INTF  = 8'hDE;
    localparam byte_t OP_R_STAT  = 8'hE2;
    localparam byte_t OP_R_REC   = 8'hEA;
    localparam byte_t OP_R_TEC   = 8'hEC;
    localparam byte_t OP_RX_FIFO = 8'h48;
    localparam byte_t OP_MRESET  = 8'h56;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL   = 3'd0,
        MODE_LOOPBACK = 3'd1,
        MODE_MONITOR  = 3'd2,
        MODE_SLEEP    = 3'd3,
        MODE_INIT     = 3'd4
    } op_mode_e;

    localparam byte_t CTRL0_RESET = byte_t'(MODE_INIT) << MODE_LSB;
    localparam byte_t STAT_RESET  = 8'h82;

    typedef enum logic [2:0] {
        K_NONE, K_WR, K_RD, K_RXF, K_TXF, K_RST
    } op_kind_e;

    typedef enum logic [2:0] {
        D_OPC, D_WRDATA, D_RDSLOT, D_RXF, D_TXF, D_DONE
    } dec_state_e;

    typedef struct packed {
        logic  wr;
        byte_t wop;
        byte_t wdata;
        logic  rd;
        byte_t rop;
        logic  mreset;
    } reg_req_t;

    function automatic op_kind_e op_kind(input byte_t op);
        case (op)
            OP_W_CTRL0, OP_W_CTRL1, OP_W_BTR0,
            OP_W_BTR1, OP_W_INTEN:              return K_WR;
            OP_R_CTRL0, OP_R_CTRL1, OP_R_BTR0, OP_R_BTR1,
            OP_R_MSTAT, OP_R_ERRF, OP_R_INTF, OP_R_STAT,
            OP_R_REC, OP_R_TEC:                 return K_RD;
            OP_RX_FIFO:                         return K_RXF;
            OP_TX_FIFO:                         return K_TXF;
            OP_MRESET:                          return K_RST;
            default:                            return K_NONE;
        endcase
    endfunction
endpackage

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  spi_sck,
    input  logic  spi_csn,
    input  logic  spi_mosi,
    output logic  spi_miso,
    input  byte_t next_byte,
    output logic  cs_act,
    output logic  byte_done,
    output byte_t byte_val
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_p, csn_p, mosi_p;
    logic                   sck_d;
    logic                   rise, fall;
    logic [BITCNT_W-1:0]    bit_cnt;
    byte_t                  rx_sh, tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            csn_p  <= '1;
            mosi_p <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_p  <= {sck_p[SYNC_STAGES-2:0], spi_sck};
            csn_p  <= {csn_p[SYNC_STAGES-2:0], spi_csn};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
            sck_d  <= sck_p[TOP];
        end
    end

    assign cs_act = ~csn_p[TOP];
    assign rise   = sck_p[TOP] & ~sck_d;
    assign fall   = ~sck_p[TOP] & sck_d;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_p[TOP]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BITCNT_W'(BYTE_W - 1)) begin
                    byte_done <= 1'b1;
                    byte_val  <= {rx_sh[BYTE_W-2:0], mosi_p[TOP]};
                end
            end
            if (fall) begin
                if (bit_cnt == '0) tx_sh <= next_byte;
                else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign spi_miso = tx_sh[BYTE_W-1];

    // R1: a completed byte can only be reported while the frame is open
    p_byte_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(cs_act));
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_act,
    input  logic     byte_done,
    input  byte_t    byte_val,
    output byte_t    next_byte,
    output reg_req_t req,
    input  byte_t    reg_rdata,
    input  byte_t    rxf_data,
    output logic     rxf_pop,
    output logic     txf_valid,
    output byte_t    txf_data
);
    dec_state_e state;
    byte_t      wr_op;
    byte_t      rd_hold;
    op_kind_e   kind;

    assign kind = op_kind(byte_val);

    always_comb begin
        req.wr     = byte_done && (state == D_WRDATA);
        req.wop    = wr_op;
        req.wdata  = byte_val;
        req.rd     = byte_done && (state == D_OPC) && (kind == K_RD);
        req.rop    = byte_val;
        req.mreset = byte_done && (state == D_OPC) && (kind == K_RST);
    end

    assign txf_valid = byte_done && (state == D_TXF);
    assign txf_data  = byte_val;
    assign rxf_pop   = byte_done && (state == D_RXF);

    always_comb begin
        case (state)
            D_RXF:    next_byte = rxf_data;
            D_RDSLOT: next_byte = rd_hold;
            default:  next_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            state   <= D_OPC;
            wr_op   <= '0;
            rd_hold <= '0;
        end else if (byte_done) begin
            case (state)
                D_OPC: begin
                    case (kind)
                        K_WR:    begin state <= D_WRDATA; wr_op <= byte_val; end
                        K_RD:    begin state <= D_RDSLOT; rd_hold <= reg_rdata; end
                        K_RXF:   state <= D_RXF;
                        K_TXF:   state <= D_TXF;
                        default: state <= D_DONE;
                    endcase
                end
                D_WRDATA, D_RDSLOT: state <= D_DONE;
                default:            state <= state;
            endcase
        end
    end

    // R1: the register port and FIFO strobes never fire together
    p_one_action_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.wr, req.rd, req.mreset, txf_valid, rxf_pop}));
    // R2: a frame commits at most one register write
    p_write_once_r2: assert property (@(posedge clk) disable iff (rst)
        req.wr |=> (state == D_DONE || state == D_OPC));
    // R12: a closed frame returns the decoder to opcode state
    p_abort_r12: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (state == D_OPC) && !req.wr);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req,
    output byte_t    rdata,
    input  byte_t    int_set,
    input  byte_t    err_set,
    input  logic     stat_load,
    input  byte_t    stat_value,
    input  byte_t    msg_stat_in,
    input  byte_t    rec_in,
    input  byte_t    tec_in,
    output byte_t    ctrl0_q,
    output byte_t    ctrl1_q,
    output byte_t    btr0_q,
    output byte_t    btr1_q,
    output byte_t    inten_q
);
    byte_t intf_q, errf_q, stat_q;
    logic  rd_intf, rd_errf;

    assign rd_intf = req.rd && (req.rop == OP_R_INTF);
    assign rd_errf = req.rd && (req.rop == OP_R_ERRF);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= CTRL0_RESET;
            ctrl1_q <= '0;
            btr0_q  <= '0;
            btr1_q  <= '0;
            inten_q <= '0;
            intf_q  <= '0;
            errf_q  <= '0;
            stat_q  <= STAT_RESET;
        end else begin
            errf_q <= (rd_errf ? '0 : errf_q) | err_set;
            if (req.mreset) begin
                ctrl0_q <= CTRL0_RESET;
                ctrl1_q <= '0;
                btr0_q  <= '0;
                btr1_q  <= '0;
                inten_q <= '0;
                intf_q  <= int_set;
                stat_q  <= STAT_RESET;
            end else begin
                intf_q <= (rd_intf ? '0 : intf_q) | int_set;
                if (stat_load) stat_q <= stat_value;
                if (req.wr) begin
                    case (req.wop)
                        OP_W_CTRL0: ctrl0_q <= req.wdata;
                        OP_W_CTRL1: ctrl1_q <= req.wdata;
                        OP_W_BTR0:  btr0_q  <= req.wdata;
                        OP_W_BTR1:  btr1_q  <= req.wdata;
                        OP_W_INTEN: inten_q <= req.wdata;
                        default:    ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (req.rop)
            OP_R_CTRL0: rdata = ctrl0_q;
            OP_R_CTRL1: rdata = ctrl1_q;
            OP_R_BTR0:  rdata = btr0_q;
            OP_R_BTR1:  rdata = btr1_q;
            OP_R_MSTAT: rdata = msg_stat_in;
            OP_R_ERRF:  rdata = errf_q;
            OP_R_INTF:  rdata = intf_q;
            OP_R_STAT:  rdata = stat_q;
            OP_R_REC:   rdata = rec_in;
            OP_R_TEC:   rdata = tec_in;
            default:    rdata = '0;
        endcase
    end

    // R5: the reset opcode lands the controller in init mode
    p_mreset_init_r5: assert property (@(posedge clk) disable iff (rst)
        req.mreset |=> ctrl0_q[BYTE_W-1:MODE_LSB] == MODE_INIT);
    // R5: the reset opcode leaves pending error flags alone
    p_mreset_keeps_err_r5: assert property (@(posedge clk) disable iff (rst)
        (req.mreset && !rd_errf && err_set == '0) |=> errf_q == $past(errf_q));
    // R7: reading interrupt flags clears them when nothing new arrives
    p_intf_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_intf && int_set == '0) |=> intf_q == '0);
    // R7: a flag raised during the read survives it
    p_intf_keep_new_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_intf && !req.mreset) |=> (intf_q & $past(int_set)) == $past(int_set));
    // R8: reading error flags clears them when nothing new arrives
    p_errf_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_errf && err_set == '0) |=> errf_q == '0);
    // R9: status changes only through its load strobe or the reset opcode
    p_stat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!stat_load && !req.mreset) |=> $stable(stat_q));
endmodule

// File: rtl/spi_cmd_target.sv
module spi_cmd_target
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [BYTE_W-1:0] int_set,
    input  logic [BYTE_W-1:0] err_set,
    input  logic              stat_load,
    input  logic [BYTE_W-1:0] stat_value,
    input  logic [BYTE_W-1:0] msg_stat_in,
    input  logic [BYTE_W-1:0] rec_in,
    input  logic [BYTE_W-1:0] tec_in,
    input  logic [BYTE_W-1:0] rxf_data,
    output logic              rxf_pop,
    output logic              txf_valid,
    output logic [BYTE_W-1:0] txf_data,
    output logic [MODE_W-1:0] cfg_mode,
    output logic [BYTE_W-1:0] cfg_ctrl1,
    output logic [BYTE_W-1:0] cfg_btr0,
    output logic [BYTE_W-1:0] cfg_btr1,
    output logic [BYTE_W-1:0] cfg_inten
);
    logic     cs_act, byte_done;
    byte_t    byte_val, next_byte, reg_rdata, ctrl0_q;
    reg_req_t req;

    spi_cmd_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .spi_sck   (spi_sck),
        .spi_csn   (spi_csn),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .next_byte (next_byte),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    spi_cmd_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .next_byte (next_byte),
        .req       (req),
        .reg_rdata (reg_rdata),
        .rxf_data  (rxf_data),
        .rxf_pop   (rxf_pop),
        .txf_valid (txf_valid),
        .txf_data  (txf_data)
    );

    spi_cmd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .rdata       (reg_rdata),
        .int_set     (int_set),
        .err_set     (err_set),
        .stat_load   (stat_load),
        .stat_value  (stat_value),
        .msg_stat_in (msg_stat_in),
        .rec_in      (rec_in),
        .tec_in      (tec_in),
        .ctrl0_q     (ctrl0_q),
        .ctrl1_q     (cfg_ctrl1),
        .btr0_q      (cfg_btr0),
        .btr1_q      (cfg_btr1),
        .inten_q     (cfg_inten)
    );

    assign cfg_mode = ctrl0_q[BYTE_W-1:MODE_LSB];

    // R12: no register write is committed outside an open frame
    p_no_write_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !cs_act |-> !req.wr && !txf_valid);
endmodule

// File: tb/spi_cmd_target_bench.sv
module spi_cmd_target_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] int_set = '0, err_set = '0, stat_value = '0;
    logic       stat_load = 1'b0;
    logic [7:0] msg_stat_in = '0, rec_in = '0, tec_in = '0;
    logic [7:0] rxf_data;
    logic       rxf_pop, txf_valid;
    logic [7:0] txf_data;
    logic [2:0] cfg_mode;
    logic [7:0] cfg_ctrl1, cfg_btr0, cfg_btr1, cfg_inten;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] tx_buf [16];
    logic [7:0] rx_buf [16];
    logic [7:0] txf_seen [16];
    int txf_cnt = 0, pop_cnt = 0;

    localparam int HALF = 8;

    always #10 clk = ~clk;

    spi_cmd_target u_spi_cmd_target (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .int_set(int_set),
        .err_set(err_set), .stat_load(stat_load), .stat_value(stat_value),
        .msg_stat_in(msg_stat_in), .rec_in(rec_in), .tec_in(tec_in),
        .rxf_data(rxf_data), .rxf_pop(rxf_pop), .txf_valid(txf_valid),
        .txf_data(txf_data), .cfg_mode(cfg_mode), .cfg_ctrl1(cfg_ctrl1),
        .cfg_btr0(cfg_btr0), .cfg_btr1(cfg_btr1), .cfg_inten(cfg_inten)
    );

    assign rxf_data = 8'hC0 + 8'(pop_cnt);

    always @(negedge clk) begin
        if (txf_valid) begin
            if (txf_cnt < 16) txf_seen[txf_cnt] = txf_data;
            txf_cnt = txf_cnt + 1;
        end
        if (rxf_pop) pop_cnt = pop_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // full bytes from tx_buf, then optional extra bits of tx_buf[n]
    task automatic frame(input int n, input int extra_bits);
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b <= n; b++) begin
            int nb;
            nb = (b < n) ? 8 : extra_bits;
            for (int i = 7; i > 7 - nb; i--) begin
                spi_mosi = tx_buf[b][i];
                repeat (HALF) @(negedge clk);
                rx_buf[b][i] = spi_miso;
                spi_sck = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] op, input logic [7:0] v);
        tx_buf[0] = op; tx_buf[1] = v;
        frame(2, 0);
    endtask

    task automatic rd_reg(input logic [7:0] op, output logic [7:0] v);
        tx_buf[0] = op; tx_buf[1] = 8'h00;
        frame(2, 0);
        v = rx_buf[1];
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R4 cfg_mode", cfg_mode, 4);
        chk("R4 cfg_ctrl1", cfg_ctrl1, 0);
        chk("R4 cfg_inten", cfg_inten, 0);
        rd_reg(8'hD2, v); chk("R4 ctrl0", v, 8'h80);
        chk("R1 opcode slot", rx_buf[0], 0);
        rd_reg(8'hD6, v); chk("R4 btr0", v, 0);
        rd_reg(8'hDE, v); chk("R4 intf", v, 0);
        rd_reg(8'hDC, v); chk("R4 errf", v, 0);
        rd_reg(8'hE2, v); chk("R4 status", v, 8'h82);
    endtask

    task automatic t_write;
        logic [7:0] v;
        wr_reg(8'h14, 8'h20); chk("R6 mode loopback", cfg_mode, 1);
        rd_reg(8'hD2, v); chk("R2 ctrl0", v, 8'h20);
        wr_reg(8'h14, 8'h60); chk("R6 mode sleep", cfg_mode, 3);
        wr_reg(8'h18, 8'h43); chk("R6 cfg_btr0", cfg_btr0, 8'h43);
        wr_reg(8'h1A, 8'h2F); rd_reg(8'hD8, v); chk("R2 btr1", v, 8'h2F);
        chk("R6 cfg_btr1", cfg_btr1, 8'h2F);
        wr_reg(8'h1C, 8'h70); chk("R2 inten", cfg_inten, 8'h70);
        tx_buf[0] = 8'h16; tx_buf[1] = 8'h11; tx_buf[2] = 8'h99;
        frame(3, 0);
        rd_reg(8'hD4, v); chk("R2 trailing byte ignored", v, 8'h11);
    endtask

    task automatic t_read_inputs;
        logic [7:0] v;
        msg_stat_in = 8'h5A; rec_in = 8'h12; tec_in = 8'h34;
        rd_reg(8'hDA, v); chk("R3 msg status", v, 8'h5A);
        rd_reg(8'hEA, v); chk("R3 rec", v, 8'h12);
        tx_buf[0] = 8'hEC; tx_buf[1] = 0; tx_buf[2] = 0;
        frame(3, 0);
        chk("R3 tec", rx_buf[1], 8'h34);
        chk("R3 later slot zero", rx_buf[2], 0);
    endtask

    task automatic t_intf;
        logic [7:0] v;
        @(negedge clk); int_set = 8'h41;
        @(negedge clk); int_set = 8'h00;
        rd_reg(8'hDE, v); chk("R7 intf read", v, 8'h41);
        rd_reg(8'hDE, v); chk("R7 intf cleared", v, 0);
    endtask

    task automatic t_errf;
        logic [7:0] v;
        @(negedge clk); err_set = 8'h85;
        @(negedge clk); err_set = 8'h00;
        rd_reg(8'hDC, v); chk("R8 errf read", v, 8'h85);
        rd_reg(8'hDC, v); chk("R8 errf cleared", v, 0);
    endtask

    task automatic t_status;
        logic [7:0] v;
        @(negedge clk); stat_value = 8'h10; stat_load = 1'b1;
        @(negedge clk); stat_load = 1'b0;
        rd_reg(8'hE2, v); chk("R9 status", v, 8'h10);
        rd_reg(8'hE2, v); chk("R9 status after read", v, 8'h10);
    endtask

    task automatic t_mreset;
        logic [7:0] v;
        wr_reg(8'h14, 8'h40);
        wr_reg(8'h18, 8'h55);
        @(negedge clk); err_set = 8'h03; int_set = 8'h08;
        @(negedge clk); err_set = 8'h00; int_set = 8'h00;
        tx_buf[0] = 8'h56;
        frame(1, 0);
        chk("R5 cfg_mode init", cfg_mode, 4);
        chk("R5 btr0 cleared", cfg_btr0, 0);
        chk("R5 inten cleared", cfg_inten, 0);
        rd_reg(8'hD2, v); chk("R5 ctrl0", v, 8'h80);
        rd_reg(8'hDE, v); chk("R5 intf cleared", v, 0);
        rd_reg(8'hE2, v); chk("R5 status", v, 8'h82);
        rd_reg(8'hDC, v); chk("R5 errf kept", v, 8'h03);
    endtask

    task automatic t_txf;
        txf_cnt = 0;
        tx_buf[0] = 8'h12; tx_buf[1] = 8'hA1; tx_buf[2] = 8'hB2; tx_buf[3] = 8'hC3;
        frame(4, 0);
        chk("R10 byte count", txf_cnt, 3);
        chk("R10 byte0", txf_seen[0], 8'hA1);
        chk("R10 byte1", txf_seen[1], 8'hB2);
        chk("R10 byte2", txf_seen[2], 8'hC3);
        chk("R10 miso zero", rx_buf[2], 0);
    endtask

    task automatic t_rxf;
        int p0;
        p0 = pop_cnt;
        tx_buf[0] = 8'h48;
        for (int i = 1; i < 5; i++) tx_buf[i] = 8'h00;
        frame(5, 0);
        chk("R11 pop count", pop_cnt - p0, 4);
        for (int i = 1; i < 5; i++)
            chk("R11 stream byte", rx_buf[i], 8'hC0 + p0 + i - 1);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        wr_reg(8'h16, 8'h11);
        tx_buf[0] = 8'h16; tx_buf[1] = 8'hFF;
        frame(1, 4);
        rd_reg(8'hD4, v); chk("R12 partial data dropped", v, 8'h11);
        tx_buf[0] = 8'hD4;
        frame(0, 5);
        rd_reg(8'hD2, v); chk("R12 fresh opcode after abort", v, 8'h80);
    endtask

    task automatic t_unknown;
        logic [7:0] v;
        tx_buf[0] = 8'h33; tx_buf[1] = 8'h77; tx_buf[2] = 8'h55;
        frame(3, 0);
        chk("R13 slot1 zero", rx_buf[1], 0);
        chk("R13 slot2 zero", rx_buf[2], 0);
        wr_reg(8'h1E, 8'hFF);
        wr_reg(8'h15, 8'hFF);
        rd_reg(8'hD2, v); chk("R13 ctrl0 unchanged", v, 8'h80);
        rd_reg(8'hD4, v); chk("R13 ctrl1 unchanged", v, 8'h11);
        chk("R13 inten unchanged", cfg_inten, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset;
        t_write;
        t_read_inputs;
        t_intf;
        t_errf;
        t_status;
        t_mreset;
        t_txf;
        t_rxf;
        t_abort;
        t_unknown;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule